// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one starting column address into the ordered list of column addresses that a memory burst visits. A one-cycle `start` pulse latches the start column, a two-bit length code (2, 4 or 8 beats) and a one-bit ordering select. On each following cycle the block presents one column address, and it marks the opening and closing beats of the burst.

The low column bits walk through an aligned block whose size equals the burst length. They either count upward and wrap, or are formed by XOR of the start bits with the beat number. The column bits above that block never change within a burst. A controller sets up the next burst by raising `start` on the closing beat, which gives back-to-back bursts with no idle cycle between them.

Top module: `burst_col_seq`

## Requirements
- R1: While and right after reset, `valid`, `first`, `last` and `bl_err` are low and `col_out` is zero.
- R2: A `start` accepted at a clock edge makes the very next cycle the opening beat: `valid` and `first` are high and `col_out` equals the latched start column.
- R3: The length code selects the beat count as 2'b01 = 2, 2'b10 = 4 and 2'b11 = 8 beats. `last` is high only on the final beat, and `valid` drops in the cycle after it unless a new burst begins.
- R4: With `burst_type` = 0 (sequential), beat i carries low bits (start + i) modulo the burst length. For example, start 5 with 8 beats gives 5,6,7,0,1,2,3,4.
- R5: With `burst_type` = 1 (interleaved), beat i carries low bits equal to the start's low bits XOR i. For example, start 5 with 8 beats gives 5,4,7,6,1,0,3,2.
- R6: Column bits at and above the aligned block (bit 1 and up for 2 beats, bit 2 and up for 4, bit 3 and up for 8) equal those of the start column on every beat. Wrapping never carries into them.
- R7: Length, type and start column are sampled only when `start` is accepted. Changing those inputs during a burst has no effect on the addresses produced.
- R8: The length code 2'b00 is not supported. It runs a 2-beat burst, and `bl_err` is high on every beat of that burst and low on the beats of supported bursts.
- R9: A `start` on the cycle where `last` is high is accepted, and the next cycle is the opening beat of the new burst with no gap.
- R10: A `start` during a burst on any beat other than the last is ignored, and the running burst completes unchanged.
- R11: While no burst is running, `col_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a new burst |
| start_col | input | 10 | First column of the burst |
| bl_code | input | 2 | Burst length code |
| burst_type | input | 1 | 0 sequential, 1 interleaved |
| col_out | output | 10 | Column address of the current beat |
| valid | output | 1 | A beat is presented this cycle |
| first | output | 1 | Opening beat of a burst |
| last | output | 1 | Final beat of a burst |
| bl_err | output | 1 | Current burst was requested with an unsupported length code |

## Verification
A corrupt beat counter shows up as a wrong low column on the very next beat. It also shows up as a `last` that comes early or late, which changes the length of the burst within at most eight cycles. A latched length, type or base that was not held would let input changes made during a burst leak into `col_out` on the following beat. A missed back-to-back acceptance shows as an idle cycle directly after `last` where an opening beat was due.

// File: rtl/burst_seq_pkg.sv
// Package: shared encodings for the burst column address sequencer.
// Assumes bursts never exceed 8 beats, so a beat index fits in BEAT_W bits.
package burst_seq_pkg;
    localparam int BEAT_W = 3;

    typedef enum logic [1:0] {
        BLC_BAD = 2'b00,
        BLC_2   = 2'b01,
        BLC_4   = 2'b10,
        BLC_8   = 2'b11
    } bl_code_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;
endpackage

// File: rtl/bl_decode.sv
// Module: bl_decode
// Converts a burst length code into a low-bit wrap mask (length - 1) and
// flags the unsupported code, which falls back to a 2-beat burst.
// Purely combinational; assumes the code is sampled by the caller.
module bl_decode
    import burst_seq_pkg::*;
#(
    parameter int MW = BEAT_W
) (
    input  bl_code_e        code,
    output logic [MW-1:0]   mask,
    output logic            bad
);
    // Map each code onto its wrap mask
    always_comb begin
        mask = '0;
        bad  = 1'b0;
        unique case (code)
            BLC_2:   mask = MW'(1);
            BLC_4:   mask = MW'(3);
            BLC_8:   mask = MW'(7);
            default: begin
                mask = MW'(1);
                bad  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/beat_counter.sv
// Module: beat_counter
// Tracks whether a burst is running and which beat is current. A start is
// accepted when idle or on the final beat; otherwise it is dropped.
// Assumes mask_in is 2^k - 1 with k <= MW.
module beat_counter #(
    parameter int MW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [MW-1:0]   mask_in,
    output logic            take,
    output logic            active,
    output logic [MW-1:0]   cnt,
    output logic [MW-1:0]   mask_q,
    output logic            first,
    output logic            last
);
    // Decide acceptance of a new burst and flag the edge beats
    always_comb begin
        last  = active && (cnt == mask_q);
        first = active && (cnt == '0);
        take  = start && (!active || last);
    end

    // Advance the beat index, load on acceptance, stop after the last beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            mask_q <= '0;
        end else if (take) begin
            active <= 1'b1;
            cnt    <= '0;
            mask_q <= mask_in;
        end else if (active) begin
            if (last) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2
    open_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (active && first));

    // R3
    idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !active);

    // R10
    busy_start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last && start) |=> (active && !first));

    // R9
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && start) |=> (active && first));
endmodule

// File: rtl/col_order.sv
// Module: col_order
// Forms the column of the current beat: low bits inside the aligned block
// follow the sequential or XOR ordering, all other bits come from the base.
// Combinational; output is forced to zero when no burst is active.
module col_order
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int MW    = BEAT_W
) (
    input  logic [COL_W-1:0] base,
    input  logic [MW-1:0]    cnt,
    input  logic [MW-1:0]    mask,
    input  order_e           order,
    input  logic             active,
    output logic [COL_W-1:0] col
);
    logic [MW-1:0] low;

    // Choose the within-block offset for this beat
    always_comb begin
        if (order == ORD_XOR) low = base[MW-1:0] ^ cnt;
        else                  low = base[MW-1:0] + cnt;
    end

    // Merge block offset and held upper bits, bit by bit
    for (genvar g = 0; g < COL_W; g++) begin : g_bit
        if (g < MW) begin : g_low
            assign col[g] = active & (mask[g] ? low[g] : base[g]);
        end else begin : g_high
            assign col[g] = active & base[g];
        end
    end
endmodule

// File: rtl/burst_col_seq.sv
// Module: burst_col_seq (top)
// Produces one column address per beat for a burst of 2, 4 or 8 beats in
// sequential or interleaved order, wrapping inside the aligned block.
// Assumes start_col and the mode inputs are valid while start is high.
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [1:0]       bl_code,
    input  logic             burst_type,
    output logic [COL_W-1:0] col_out,
    output logic             valid,
    output logic             first,
    output logic             last,
    output logic             bl_err
);
    localparam int MW = BEAT_W;

    logic [MW-1:0]    dec_mask;
    logic             dec_bad;
    logic             take;
    logic             active;
    logic [MW-1:0]    cnt;
    logic [MW-1:0]    mask_q;
    logic [COL_W-1:0] base_q;
    order_e           order_q;
    logic             bad_q;

    bl_decode #(.MW(MW)) dec_i (
        .code (bl_code_e'(bl_code)),
        .mask (dec_mask),
        .bad  (dec_bad)
    );

    beat_counter #(.MW(MW)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mask_in (dec_mask),
        .take    (take),
        .active  (active),
        .cnt     (cnt),
        .mask_q  (mask_q),
        .first   (first),
        .last    (last)
    );

    // Hold base column, ordering and error flag for the whole burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= ORD_SEQ;
            bad_q   <= 1'b0;
        end else if (take) begin
            base_q  <= start_col;
            order_q <= order_e'(burst_type);
            bad_q   <= dec_bad;
        end
    end

    col_order #(.COL_W(COL_W), .MW(MW)) ord_i (
        .base   (base_q),
        .cnt    (cnt),
        .mask   (mask_q),
        .order  (order_q),
        .active (active),
        .col    (col_out)
    );

    // Drive beat qualifiers
    always_comb begin
        valid  = active;
        bl_err = active & bad_q;
    end

    // R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !last) |=> $stable(col_out[COL_W-1:MW]));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !last) |=> $stable(bl_err));

    // R2
    open_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (col_out == $past(start_col)));

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (col_out == '0 && !bl_err));
endmodule

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [9:0] start_col = '0;
    logic [1:0] bl_code = 2'b01;
    logic       burst_type = 1'b0;
    logic [9:0] col_out;
    logic       valid, first, last, bl_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .bl_code(bl_code), .burst_type(burst_type), .col_out(col_out),
        .valid(valid), .first(first), .last(last), .bl_err(bl_err)
    );

    // {type, code[1:0], col[9:0]}
    localparam logic [12:0] VEC [9] = '{
        {1'b0, 2'b11, 10'd5},
        {1'b1, 2'b11, 10'd5},
        {1'b0, 2'b10, 10'h3FE},
        {1'b1, 2'b10, 10'h1F3},
        {1'b0, 2'b01, 10'h0FF},
        {1'b1, 2'b01, 10'h200},
        {1'b0, 2'b00, 10'h157},
        {1'b1, 2'b11, 10'h3FF},
        {1'b0, 2'b11, 10'h008}
    };

    function automatic int len_of(input logic [1:0] c);
        case (c)
            2'b10:   return 4;
            2'b11:   return 8;
            default: return 2;
        endcase
    endfunction

    function automatic logic [9:0] exp_col(input logic [9:0] c, input int len,
                                           input logic t, input int i);
        logic [9:0] m, lo;
        m  = 10'(len - 1);
        lo = t ? (c ^ 10'(i)) : (c + 10'(i));
        return (c & ~m) | (lo & m);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_beat(input logic [9:0] c, input int len, input logic t,
                            input logic bad, input int i);
        chk("R4/R5/R6 col", {22'd0, col_out}, {22'd0, exp_col(c, len, t, i)});
        chk("R2 valid", {31'd0, valid}, 32'd1);
        chk("R2 first", {31'd0, first}, {31'd0, (i == 0)});
        chk("R3 last", {31'd0, last}, {31'd0, (i == len - 1)});
        chk("R8 bl_err", {31'd0, bl_err}, {31'd0, bad});
    endtask

    task automatic chk_idle();
        chk("R3 valid low", {31'd0, valid}, 32'd0);
        chk("R11 col zero", {22'd0, col_out}, 32'd0);
    endtask

    // Run a burst, scrambling the mode inputs while it runs (R7)
    task automatic run_burst(input logic [9:0] c, input logic [1:0] code, input logic t);
        int len;
        len = len_of(code);
        @(negedge clk);
        start = 1'b1; start_col = c; bl_code = code; burst_type = t;
        @(negedge clk);
        start = 1'b0; start_col = ~c; bl_code = ~code; burst_type = ~t;
        for (int i = 0; i < len; i++) begin
            chk_beat(c, len, t, (code == 2'b00), i);
            @(negedge clk);
        end
        chk_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 valid", {31'd0, valid}, 32'd0);
        chk("R1 first", {31'd0, first}, 32'd0);
        chk("R1 last", {31'd0, last}, 32'd0);
        chk("R1 bl_err", {31'd0, bl_err}, 32'd0);
        chk("R1 col", {22'd0, col_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle();

        // R4 R5 R6 R7 R8: table walk
        for (int v = 0; v < 9; v++) begin
            run_burst(VEC[v][9:0], VEC[v][11:10], VEC[v][12]);
        end

        // R10: start mid-burst is dropped
        @(negedge clk);
        start = 1'b1; start_col = 10'd3; bl_code = 2'b11; burst_type = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk_beat(10'd3, 8, 1'b0, 1'b0, i);
            start = (i == 2); start_col = 10'h100; bl_code = 2'b01; burst_type = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        chk_idle();

        // R9: back-to-back bursts
        @(negedge clk);
        start = 1'b1; start_col = 10'd1; bl_code = 2'b10; burst_type = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk_beat(10'd1, 4, 1'b1, 1'b0, i);
            if (i == 3) begin
                start = 1'b1; start_col = 10'h2C6; bl_code = 2'b11; burst_type = 1'b0;
            end
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 8; i++) begin
            chk_beat(10'h2C6, 8, 1'b0, 1'b0, i);
            @(negedge clk);
        end
        chk_idle();

        // R1: reset in the middle of a burst
        start = 1'b1; start_col = 10'd7; bl_code = 2'b00; burst_type = 1'b0;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset valid", {31'd0, valid}, 32'd0);
        chk("R1 mid reset err", {31'd0, bl_err}, 32'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule